// File: doc/BRIEF.md
# Dual bridge-ADC serial reader

This block collects conversion results from two 24-bit bridge-sensor converters that are clocked by one shared serial clock line. Each converter drives its own data line, which also serves as its ready flag: a converter pulls its line low when a conversion is waiting. The block synchronizes both lines and waits until both are low. It then issues clock pulses on the shared line and shifts one bit from each converter on every pulse. Each 24-bit two's-complement word is widened to a 32-bit signed value.

Every read uses 25 clock pulses. The first 24 carry the data bits, most significant bit first. The last pulse carries no data and tells both converters to use channel A at gain 128 for their next conversion, which is the only mode this block uses. The clock high and low times are parameters counted in system-clock cycles. The high time must stay well below the converters' power-down threshold of roughly 60 µs. When the last pulse ends, both results are registered together with a one-cycle valid strobe, and the block goes back to waiting for the next pair of ready flags.

Top module: `dual_bridge_reader`

## Requirements
- R1: No clock pulse is issued until both synchronized data lines are low at the same time. One low line alone never starts a read.
- R2: Each clock pulse is high for exactly HIGH_CYC system cycles. Between two pulses of a read, the clock is low for at least LOW_CYC cycles.
- R3: A read issues exactly 25 rising edges on the shared clock: DATA_BITS (24) data pulses plus one trailing pulse.
- R4: On each of the first 24 pulses, both data lines are sampled in parallel. The first bit sampled becomes bit 23 of the raw word and the last becomes bit 0.
- R5: The 24-bit raw word is two's complement and is widened by copying bit 23 into bits 31:24. Examples: 0x000000 gives 0, 0x7FFFFF gives 8388607, 0x800000 gives -8388608, and 0xFFFFFF gives -1.
- R6: valid_o is high for exactly one cycle per completed read, and both results update in that same cycle. The results then hold their values until the next read completes.
- R7: After a read completes, the block waits for both ready flags again, so reads can follow one another without limit.
- R8: While reset is asserted, the clock output and valid_o are low and both results are zero. A reset during a read abandons that read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| dout_a_i | input | 1 | Data/ready line of converter A (low = ready) |
| dout_b_i | input | 1 | Data/ready line of converter B (low = ready) |
| sclk_o | output | 1 | Shared serial clock to both converters |
| valid_o | output | 1 | One-cycle strobe marking new results |
| result_a_o | output | 32 | Sign-extended result of converter A |
| result_b_o | output | 32 | Sign-extended result of converter B |

## Verification
The assertions assume that the converters behave as the protocol requires. Each converter changes its data line only after a rising edge of the shared clock, or when it signals ready. Each line settles within the high and low phase of a pulse, and it stays high after the trailing pulse until the next conversion is ready. The bench's converter model drives a new bit on each rising clock edge, forces the line high after the 25th edge, and pulls it low only when the bench presents a new word. It also staggers the two ready flags to exercise the start condition.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dbr_state_e;
endpackage

// File: rtl/dbr_sync.sv
module dbr_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  // Lines idle high, so reset to 1 (not ready).
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= 1'b1;
        sync_q <= 1'b1;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end
    assign q_o[g] = sync_q;
  end
endmodule

// File: rtl/dbr_capture.sv
module dbr_capture #(
  parameter int unsigned IN_W  = 24,
  parameter int unsigned OUT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             shift_en_i,
  input  logic             bit_i,
  output logic [OUT_W-1:0] value_o
);
  localparam int unsigned EXT_W = OUT_W - IN_W;

  logic [IN_W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (shift_en_i) sh_d = {sh_q[IN_W-2:0], bit_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else if (shift_en_i) sh_q <= sh_d;
  end

  assign value_o = {{EXT_W{sh_q[IN_W-1]}}, sh_q};

  assert_msb_first_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_en_i |=> (sh_q[0] == $past(bit_i)) && (sh_q[IN_W-1:1] == $past(sh_q[IN_W-2:0])));
endmodule

// File: rtl/dual_bridge_reader.sv
module dual_bridge_reader
  import dbr_pkg::*;
#(
  parameter int unsigned HIGH_CYC  = 8,
  parameter int unsigned LOW_CYC   = 8,
  parameter int unsigned DATA_BITS = 24,
  parameter int unsigned OUT_W     = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dout_a_i,
  input  logic             dout_b_i,
  output logic             sclk_o,
  output logic             valid_o,
  output logic [OUT_W-1:0] result_a_o,
  output logic [OUT_W-1:0] result_b_o
);
  localparam int unsigned PULSES = DATA_BITS + 1;
  localparam int unsigned MAXPH  = (HIGH_CYC > LOW_CYC) ? HIGH_CYC : LOW_CYC;
  localparam int unsigned PH_W   = $clog2(MAXPH + 1);
  localparam int unsigned PC_W   = $clog2(PULSES + 1);
  localparam int unsigned NCH    = 2;

  logic [NCH-1:0]   line_s;
  logic [OUT_W-1:0] cap [NCH];

  dbr_sync #(.WIDTH(NCH)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({dout_b_i, dout_a_i}),
    .q_o   (line_s)
  );

  dbr_state_e      st_q, st_d;
  logic            sclk_q, sclk_d;
  logic [PH_W-1:0] ph_q, ph_d;
  logic [PC_W-1:0] pc_q, pc_d;
  logic            sample, finish, shift_en;
  logic            valid_q;
  logic [OUT_W-1:0] res_a_q, res_b_q;

  always_comb begin
    st_d   = st_q;
    sclk_d = sclk_q;
    ph_d   = ph_q;
    pc_d   = pc_q;
    sample = 1'b0;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (line_s == '0) begin
          st_d   = ST_RUN;
          sclk_d = 1'b1;
          ph_d   = '0;
          pc_d   = '0;
        end
      end
      ST_RUN: begin
        ph_d = ph_q + 1'b1;
        if (sclk_q && ph_q == PH_W'(HIGH_CYC - 1)) begin
          sclk_d = 1'b0;
          ph_d   = '0;
        end else if (!sclk_q && ph_q == PH_W'(LOW_CYC - 1)) begin
          sample = 1'b1;
          pc_d   = pc_q + 1'b1;
          ph_d   = '0;
          if (pc_q == PC_W'(PULSES - 1)) begin
            finish = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            sclk_d = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign shift_en = sample && (pc_q < PC_W'(DATA_BITS));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dbr_capture #(.IN_W(DATA_BITS), .OUT_W(OUT_W)) i_capture (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .shift_en_i(shift_en),
      .bit_i     (line_s[c]),
      .value_o   (cap[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sclk_q <= 1'b0;
      ph_q   <= '0;
      pc_q   <= '0;
    end else begin
      st_q   <= st_d;
      sclk_q <= sclk_d;
      ph_q   <= ph_d;
      pc_q   <= pc_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= finish;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_q <= '0;
      res_b_q <= '0;
    end else if (finish) begin
      res_a_q <= cap[0];
      res_b_q <= cap[1];
    end
  end

  assign sclk_o     = sclk_q;
  assign valid_o    = valid_q;
  assign result_a_o = res_a_q;
  assign result_b_o = res_b_q;

  // Checker state: length of the current high phase.
  logic [PH_W:0] hi_run_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_run_q <= '0;
    else if (sclk_q) hi_run_q <= hi_run_q + 1'b1;
    else             hi_run_q <= '0;
  end

  assert_start_both_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(sclk_o) && $past(st_q == ST_IDLE)) |-> $past(line_s == '0));

  assert_high_bounded_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_run_q <= (PH_W+1)'(HIGH_CYC));

  assert_pulse_limit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_q <= PC_W'(PULSES));

  assert_valid_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  assert_hold_results_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(result_a_o) && $stable(result_b_o));

  assert_idle_after_read_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (st_q == ST_IDLE) && !sclk_o);
endmodule

// File: tb/test_dual_bridge_reader.sv
module test_dual_bridge_reader;
  localparam int HIGH_CYC = 8;
  localparam int LOW_CYC  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk, valid;
  logic [31:0] res_a, res_b;
  logic [31:0] hold_a, hold_b;

  always #4 clk = ~clk;

  // Converter model: shared edge counter, one word per converter.
  logic [23:0] wa = '0, wb = '0;
  logic arm_a = 1'b0, arm_b = 1'b0, mclr = 1'b0;
  int edge_cnt = 0;
  logic da, db;

  always @(posedge sclk or posedge mclr) begin
    if (mclr) edge_cnt <= 0;
    else      edge_cnt <= edge_cnt + 1;
  end

  assign da = !arm_a ? 1'b1 : (edge_cnt == 0) ? 1'b0 :
              (edge_cnt <= 24) ? wa[24-edge_cnt] : 1'b1;
  assign db = !arm_b ? 1'b1 : (edge_cnt == 0) ? 1'b0 :
              (edge_cnt <= 24) ? wb[24-edge_cnt] : 1'b1;

  dual_bridge_reader i_dual_bridge_reader (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .dout_a_i  (da),
    .dout_b_i  (db),
    .sclk_o    (sclk),
    .valid_o   (valid),
    .result_a_o(res_a),
    .result_b_o(res_b)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] widen(input logic [23:0] raw);
    logic signed [31:0] t;
    t = $signed({raw, 8'h00});
    return 32'(t >>> 8);
  endfunction

  // Pulse-shape monitor (R2).
  int hcnt = 0, lcnt = 0;
  int hmin = 1000, hmax = 0, lmin = 1000;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst_n) begin
      hcnt = 0; lcnt = 0;
    end else begin
      if (sclk) begin
        if (!sclk_prev && lcnt > 0 && lcnt < lmin) lmin = lcnt;
        hcnt++; lcnt = 0;
      end else begin
        if (sclk_prev) begin
          if (hcnt < hmin) hmin = hcnt;
          if (hcnt > hmax) hmax = hcnt;
        end
        hcnt = 0; lcnt++;
      end
    end
    sclk_prev = sclk;
  end

  task automatic present(input logic [23:0] a, input logic [23:0] b);
    @(negedge clk);
    wa = a; wb = b;
    mclr = 1'b1; #1 mclr = 1'b0;
    arm_a = 1'b1; arm_b = 1'b1;
  endtask

  task automatic await_valid(output bit seen);
    seen = 1'b0;
    for (int i = 0; i < 3000 && !seen; i++) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
  endtask

  localparam logic [47:0] VEC [0:5] = '{
    {24'h000000, 24'h7FFFFF},
    {24'h800000, 24'hFFFFFF},
    {24'hA5A5A5, 24'h5A5A5A},
    {24'h000001, 24'hFFFFFE},
    {24'h123456, 24'hFEDCBA},
    {24'hFFFFFF, 24'h000000}
  };

  initial begin
    #2000000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    bit seen;
    // R8: reset state
    repeat (3) @(negedge clk);
    check("R8 sclk in reset", 32'(sclk), 32'd0);
    check("R8 valid in reset", 32'(valid), 32'd0);
    check("R8 result_a in reset", res_a, 32'd0);
    check("R8 result_b in reset", res_b, 32'd0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // Table walk: R3 R4 R5 R6 R7 (back-to-back reads)
    for (int v = 0; v < 6; v++) begin
      present(VEC[v][47:24], VEC[v][23:0]);
      await_valid(seen);
      check("R6 valid seen", 32'(seen), 32'd1);
      check("R4/R5 result_a", res_a, widen(VEC[v][47:24]));
      check("R4/R5 result_b", res_b, widen(VEC[v][23:0]));
      check("R3 pulse count", 32'(edge_cnt), 32'd25);
      hold_a = res_a; hold_b = res_b;
      @(negedge clk);
      check("R6 one-cycle valid", 32'(valid), 32'd0);
      arm_a = 1'b0; arm_b = 1'b0;
      repeat (20) @(negedge clk);
      check("R6 result_a held", res_a, hold_a);
      check("R6 result_b held", res_b, hold_b);
    end

    // R5 fixed points
    check("R5 zero", widen(24'h000000), 32'd0);
    check("R5 max", widen(24'h7FFFFF), 32'd8388607);

    // R1: only A ready, then only B ready
    @(negedge clk);
    wa = 24'h400001; wb = 24'hC00003;
    mclr = 1'b1; #1 mclr = 1'b0;
    arm_a = 1'b1;
    repeat (100) @(negedge clk);
    check("R1 no pulse with only A ready", 32'(edge_cnt), 32'd0);
    check("R1 sclk low with only A ready", 32'(sclk), 32'd0);
    arm_b = 1'b1;
    await_valid(seen);
    check("R1 read after both ready", res_a, 32'h00400001);
    check("R1 read after both ready B", res_b, 32'hFFC00003);
    @(negedge clk);
    arm_a = 1'b0; arm_b = 1'b0;
    repeat (10) @(negedge clk);
    @(negedge clk);
    wa = 24'h00FF00; wb = 24'h00000F;
    mclr = 1'b1; #1 mclr = 1'b0;
    arm_b = 1'b1;
    repeat (100) @(negedge clk);
    check("R1 no pulse with only B ready", 32'(edge_cnt), 32'd0);
    arm_a = 1'b1;
    await_valid(seen);
    check("R1 B-first result_a", res_a, 32'h0000FF00);
    @(negedge clk);
    arm_a = 1'b0; arm_b = 1'b0;

    // R2 pulse shape
    check("R2 min high", 32'(hmin), 32'(HIGH_CYC));
    check("R2 max high", 32'(hmax), 32'(HIGH_CYC));
    check("R2 min low gap", 32'(lmin >= LOW_CYC), 32'd1);

    // R8: reset mid-read
    repeat (10) @(negedge clk);
    present(24'h777777, 24'h888888);
    repeat (100) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 sclk after mid-read reset", 32'(sclk), 32'd0);
    check("R8 result_a after reset", res_a, 32'd0);
    check("R8 valid after reset", 32'(valid), 32'd0);
    arm_a = 1'b0; arm_b = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R7: recovery read after reset
    present(24'h800000, 24'h000002);
    await_valid(seen);
    check("R7 recovery result_a", res_a, 32'hFF800000);
    check("R7 recovery result_b", res_b, 32'h00000002);
    check("R3 recovery pulse count", 32'(edge_cnt), 32'd25);
    @(negedge clk);
    arm_a = 1'b0; arm_b = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule